// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Latched Overcurrent Shutdown

This block sits between a ballast controller's digital command pins and its four gate drivers. It passes the high-side and low-side half-bridge commands, the power-factor stage command and the filament-heater command to their gate outputs, but only while the mode controller has enabled the drivers. All four commands are registered once, so every gate output follows its command one clock later.

Two protections act on the half-bridge pair alone. When both half-bridge commands are high together, both half-bridge gates are blanked for as long as the overlap lasts. A current-sense comparator flag, synchronized through two flip-flops, trips an overcurrent latch while the protection enable is high. The latch forces both half-bridge gates low and raises a fault flag until the two half-bridge commands are low together and the synchronized comparator flag has also dropped. Dropping the protection enable, as the mode controller does on leaving operating mode or on supply undervoltage, clears the latch and holds the fault flag low.

The latch is a three-state machine. In `OCP_OFF` protection is disabled and the flag is low. Transition "arm" goes to `OCP_ARMED` when the protection enable is high and the synchronized flag is low; transition "trip" goes to `OCP_TRIPPED` from `OCP_OFF` or `OCP_ARMED` when the protection enable is high and the synchronized flag is high. Transition "release" returns from `OCP_TRIPPED` to `OCP_ARMED` when both registered half-bridge commands are low and the synchronized flag is low. Transition "disarm" returns to `OCP_OFF` from any state when the protection enable is low.

Top module: `hb_guard`

## Requirements
- R1: While reset is asserted, and at the first sampling point after it, all four gate outputs and the fault flag are low.
- R2: With the drivers enabled, no fault and no overlap, each gate output equals its command input as sampled at the previous rising clock edge.
- R3: When the driver enable sampled at the previous edge is low, all four gate outputs are low regardless of the commands.
- R4: When the high-side and low-side commands sampled at the previous edge are both high, both half-bridge gate outputs are low.
- R5: With protection enabled, a comparator flag held high raises the fault flag, and forces both half-bridge gates low, at the third rising edge after the flag is applied.
- R6: Once raised, the fault flag stays high until an edge at which the registered high-side and low-side commands are both low and the synchronized comparator flag is low; it drops at that edge.
- R7: When the synchronized comparator flag is high in the same cycle that the release condition on the commands holds, the fault flag stays high.
- R8: A low protection enable at a rising edge clears the fault flag at that edge, and the comparator flag has no effect on the fault flag while the protection enable stays low.
- R9: The power-factor and heater gate outputs are not affected by the fault flag or by the half-bridge overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Driver enable from the mode controller |
| prot_en | input | 1 | Overcurrent protection enable (high only in operating mode) |
| sense_trip | input | 1 | Asynchronous current-sense comparator flag |
| cmd_hs | input | 1 | High-side half-bridge command |
| cmd_ls | input | 1 | Low-side half-bridge command |
| cmd_pfc | input | 1 | Power-factor stage command |
| cmd_heat | input | 1 | Filament-heater command |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| gate_pfc | output | 1 | Power-factor gate command |
| gate_heat | output | 1 | Heater gate command |
| fault | output | 1 | Latched overcurrent flag |

## Verification
Commands and the driver enable reach the gates one rising edge after they are applied, the comparator flag reaches the fault flag on the third edge, and release or disarm act on the edge that samples their condition. The bench drives inputs on falling edges and keeps a behavioural model that is updated on each rising edge from a history queue of sampled comparator values, so these latencies come out of the queue depth rather than a register copy. Every output is compared on each falling edge, and directed checks at hand-counted falling edges pin down the trip, release, trip-wins and disarm cases.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;

    typedef enum logic [1:0] {
        OCP_OFF     = 2'd0,
        OCP_ARMED   = 2'd1,
        OCP_TRIPPED = 2'd2
    } ocp_state_t;

    localparam int unsigned CMD_W    = 4;
    localparam int unsigned IDX_HS   = 0;
    localparam int unsigned IDX_LS   = 1;
    localparam int unsigned IDX_PFC  = 2;
    localparam int unsigned IDX_HEAT = 3;

endpackage

// File: rtl/hb_sense_sync.sv
module hb_sense_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[TOP];

endmodule

// File: rtl/hb_cmd_stage.sv
module hb_cmd_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_d,
    input  logic [W-1:0] cmd_d,
    output logic         en_q,
    output logic [W-1:0] cmd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cmd_q <= '0;
        end else begin
            en_q  <= en_d;
            cmd_q <= cmd_d;
        end
    end

    a_r3_enable_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |=> !en_q);

endmodule

// File: rtl/hb_ocp_fsm.sv
module hb_ocp_fsm
    import hb_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prot_en,
    input  logic trip_sync,
    input  logic hs_q,
    input  logic ls_q,
    output logic fault
);
    ocp_state_t state, state_nx;
    logic       release_ok;

    assign release_ok = !hs_q && !ls_q && !trip_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCP_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!prot_en) begin
            state_nx = OCP_OFF;                    // disarm
        end else begin
            unique case (state)
                OCP_OFF:     state_nx = trip_sync ? OCP_TRIPPED : OCP_ARMED;
                OCP_ARMED:   if (trip_sync)  state_nx = OCP_TRIPPED;
                OCP_TRIPPED: if (release_ok) state_nx = OCP_ARMED;
                default:     state_nx = OCP_OFF;
            endcase
        end
    end

    always_comb begin
        fault = (state == OCP_TRIPPED);
    end

    a_r5_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && trip_sync) |=> fault);

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && prot_en && !hs_q && !ls_q && !trip_sync) |=> !fault);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && prot_en && (hs_q || ls_q)) |=> fault);

    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> !fault);

endmodule

// File: rtl/hb_guard.sv
module hb_guard
    import hb_guard_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic prot_en,
    input  logic sense_trip,
    input  logic cmd_hs,
    input  logic cmd_ls,
    input  logic cmd_pfc,
    input  logic cmd_heat,
    output logic gate_hs,
    output logic gate_ls,
    output logic gate_pfc,
    output logic gate_heat,
    output logic fault
);
    logic [CMD_W-1:0] cmd_d, cmd_q;
    logic             en_q;
    logic             trip_sync;
    logic             overlap;

    always_comb begin
        cmd_d           = '0;
        cmd_d[IDX_HS]   = cmd_hs;
        cmd_d[IDX_LS]   = cmd_ls;
        cmd_d[IDX_PFC]  = cmd_pfc;
        cmd_d[IDX_HEAT] = cmd_heat;
    end

    hb_cmd_stage #(.W(CMD_W)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .en_d  (drv_en),
        .cmd_d (cmd_d),
        .en_q  (en_q),
        .cmd_q (cmd_q)
    );

    hb_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sense_trip),
        .q_sync  (trip_sync)
    );

    hb_ocp_fsm u_ocp (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_en   (prot_en),
        .trip_sync (trip_sync),
        .hs_q      (cmd_q[IDX_HS]),
        .ls_q      (cmd_q[IDX_LS]),
        .fault     (fault)
    );

    assign overlap = cmd_q[IDX_HS] && cmd_q[IDX_LS];

    always_comb begin
        gate_hs   = en_q && cmd_q[IDX_HS] && !overlap && !fault;
        gate_ls   = en_q && cmd_q[IDX_LS] && !overlap && !fault;
        gate_pfc  = en_q && cmd_q[IDX_PFC];
        gate_heat = en_q && cmd_q[IDX_HEAT];
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hs && cmd_ls) |=> (!gate_hs && !gate_ls));

    a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (!gate_hs && !gate_ls && !gate_pfc && !gate_heat));

    a_r5_fault_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!gate_hs && !gate_ls));

    a_r9_pfc_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && cmd_pfc) |=> gate_pfc);

endmodule

// File: tb/hb_guard_tb.sv
module hb_guard_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 0, prot_en = 0, sense_trip = 0;
    logic cmd_hs = 0, cmd_ls = 0, cmd_pfc = 0, cmd_heat = 0;
    logic gate_hs, gate_ls, gate_pfc, gate_heat, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hb_guard u_dut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .prot_en(prot_en),
        .sense_trip(sense_trip), .cmd_hs(cmd_hs), .cmd_ls(cmd_ls),
        .cmd_pfc(cmd_pfc), .cmd_heat(cmd_heat), .gate_hs(gate_hs),
        .gate_ls(gate_ls), .gate_pfc(gate_pfc), .gate_heat(gate_heat),
        .fault(fault)
    );

    // behavioural reference: values seen at the previous edge, plus a
    // queue of comparator samples, one pushed per rising edge
    bit m_en, m_hs, m_ls, m_pfc, m_ht, m_fault;
    bit sense_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_hs = 0; m_ls = 0; m_pfc = 0; m_ht = 0; m_fault = 0;
            sense_hist = {1'b0, 1'b0};
        end else begin
            bit seen;
            seen = sense_hist[sense_hist.size() - 2];
            if (!prot_en)                          m_fault = 0;
            else if (seen)                         m_fault = 1;
            else if (m_fault && !m_hs && !m_ls)    m_fault = 0;
            m_en = drv_en; m_hs = cmd_hs; m_ls = cmd_ls;
            m_pfc = cmd_pfc; m_ht = cmd_heat;
            sense_hist.push_back(sense_trip);
            if (sense_hist.size() > 4) void'(sense_hist.pop_front());
        end
    end

    task automatic chk(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_hs, e_ls;
            e_hs = m_en && m_hs && !(m_hs && m_ls) && !m_fault;
            e_ls = m_en && m_ls && !(m_hs && m_ls) && !m_fault;
            chk("R5", "fault", fault, m_fault);
            chk("R2", "gate_hs", gate_hs, e_hs);
            chk("R4", "gate_ls", gate_ls, e_ls);
            chk("R9", "gate_pfc", gate_pfc, m_en && m_pfc);
            chk("R9", "gate_heat", gate_heat, m_en && m_ht);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(logic hs, logic ls, logic pfc, logic ht);
        cmd_hs = hs; cmd_ls = ls; cmd_pfc = pfc; cmd_heat = ht;
    endtask

    initial begin
        #1;
        chk("R1", "gate_hs in reset", gate_hs, 1'b0);
        chk("R1", "fault in reset", fault, 1'b0);
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1", "gate_ls after reset", gate_ls, 1'b0);
        chk("R1", "gate_pfc after reset", gate_pfc, 1'b0);

        // R3: commands ignored while drivers disabled
        drive(1, 0, 1, 1);
        cyc(1);
        chk("R3", "gate_hs disabled", gate_hs, 1'b0);
        chk("R3", "gate_heat disabled", gate_heat, 1'b0);

        drv_en = 1; prot_en = 1;
        cyc(1);
        chk("R2", "gate_hs latency", gate_hs, 1'b1);
        chk("R2", "gate_pfc latency", gate_pfc, 1'b1);
        drive(0, 1, 0, 1);
        cyc(1);
        chk("R2", "gate_ls latency", gate_ls, 1'b1);
        chk("R2", "gate_hs off", gate_hs, 1'b0);

        // R4: overlap blanks both
        drive(1, 1, 1, 0);
        cyc(1);
        chk("R4", "gate_hs overlap", gate_hs, 1'b0);
        chk("R4", "gate_ls overlap", gate_ls, 1'b0);
        chk("R9", "gate_pfc during overlap", gate_pfc, 1'b1);
        cyc(2);
        drive(1, 0, 1, 0);
        cyc(1);
        chk("R4", "gate_hs after overlap", gate_hs, 1'b1);

        // R5: trip with high side running
        sense_trip = 1;
        cyc(2);
        chk("R5", "fault before third edge", fault, 1'b0);
        cyc(1);
        chk("R5", "fault at third edge", fault, 1'b1);
        chk("R5", "gate_hs blanked", gate_hs, 1'b0);
        chk("R9", "gate_pfc under fault", gate_pfc, 1'b1);
        sense_trip = 0;
        cyc(4);
        chk("R6", "fault held with hs high", fault, 1'b1);

        // R7: commands low while comparator still high -> stays latched
        sense_trip = 1;
        cyc(2);
        drive(0, 0, 0, 1);
        cyc(1);
        chk("R7", "fault with release and trip", fault, 1'b1);
        cyc(2);
        chk("R7", "fault still held", fault, 1'b1);
        sense_trip = 0;
        cyc(2);
        chk("R6", "fault held until sync drops", fault, 1'b1);
        cyc(1);
        chk("R6", "fault released", fault, 1'b0);
        drive(0, 1, 0, 0);
        cyc(1);
        chk("R6", "gate_ls after release", gate_ls, 1'b1);

        // R8: disarm clears latch and ignores comparator
        sense_trip = 1;
        cyc(3);
        chk("R5", "fault retripped", fault, 1'b1);
        prot_en = 0;
        cyc(1);
        chk("R8", "fault cleared by disarm", fault, 1'b0);
        cyc(4);
        chk("R8", "comparator ignored", fault, 1'b0);
        chk("R8", "gate_ls unblanked", gate_ls, 1'b1);
        sense_trip = 0;
        cyc(3);
        prot_en = 1;

        // R3: disable mid-run
        drv_en = 0;
        drive(1, 0, 1, 1);
        cyc(1);
        chk("R3", "gate_pfc disabled", gate_pfc, 1'b0);
        drv_en = 1;

        // mixed patterns checked against the model every cycle
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom;
            drive(r[0], r[1], r[2], r[3]);
            if (r[7:4] == 0) sense_trip = ~sense_trip;
            if (r[12:8] == 0) prot_en = ~prot_en;
            if (r[17:13] == 0) drv_en = ~drv_en;
            cyc(1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule